// File: doc/BRIEF.md
# USB Device Interrupt Flag Controller

This block collects the interrupt causes of a USB device function and turns them into one prioritised interrupt request. It has eight event flags: start of frame, suspend, resume, bus reset, CRC error, underflow, overflow and stall. Software reaches these flags at two register addresses. At one address, writing a one sets a flag. At the other, writing a one clears it. Both addresses read back the same flag value. Two transaction flags, one for transfer complete and one for SETUP complete, sit in their own register, and a two-bit enable register gates them.

Single-cycle strobes from the packet engine set the flags. An internal idle timer counts consecutive idle samples of the bus and raises the suspend flag once the bus has stayed idle for a programmable number of clock cycles. The default number of cycles equals 3 ms at 16 MHz. Raising the suspend flag also puts the block into a suspend state. While the block is in that state, the first non-idle bus sample raises the resume flag and the block leaves the suspend state. The request output carries the programmed two-bit level whenever a cause is pending, and is zero otherwise.

Register map (`reg_addr`): 0 sets flags, 1 clears flags, 2 is the transaction enable register, 3 is the level register, 4 is the transaction flag register. Reads at any other address return zero.

Top module: `usb_irq_flags`

## Requirements
- R1: After reset, every flag, the enable register, the level register and the suspend state are zero, and `irq_level` is zero.
- R2: A write at address 0 sets each flag whose `reg_wdata` bit is one. Flags whose bit is zero keep their value.
- R3: A write at address 1 clears each flag whose `reg_wdata` bit is one. Flags whose bit is zero keep their value.
- R4: A read at address 0 and a read at address 1 both return the current flags. The bit order is 7 SOF, 6 suspend, 5 resume, 4 bus reset, 3 CRC, 2 underflow, 1 overflow, 0 stall.
- R5: Each event strobe sets its flag on the clock edge at which the strobe is sampled. If a clear write hits the same bit on the same edge, the hardware set wins.
- R6: The suspend flag (bit 6) sets on the edge that samples the `IDLE_CYCLES`-th consecutive idle bus sample. Any non-idle sample restarts the count, and one idle stretch sets the flag at most once.
- R7: Setting the suspend flag also sets `suspended`. The resume flag (bit 5) sets only when the bus is sampled non-idle while `suspended` is high, and that same non-idle sample clears `suspended`.
- R8: At address 2, bit 1 enables the transfer-complete flag and bit 0 enables the SETUP-complete flag. Bits 7:2 read as zero and ignore writes.
- R9: At address 4, bit 1 is the transfer-complete flag and bit 0 is the SETUP-complete flag. The strobes set them, and writing a one clears them. Zero bits and bits 7:2 have no effect.
- R10: The level register sits at address 3, bits 1:0, and bits 7:2 read as zero. `irq_level` equals the level whenever any flag at address 0 is set or any enabled transaction flag is set. Otherwise `irq_level` is zero, and it is always zero when the level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| ev_sof | input | 1 | Start-of-frame strobe |
| ev_bus_reset | input | 1 | Bus reset detected strobe |
| ev_crc_err | input | 1 | CRC error strobe |
| ev_underflow | input | 1 | Buffer underflow strobe |
| ev_overflow | input | 1 | Buffer overflow strobe |
| ev_stall | input | 1 | Stall handshake strobe |
| ev_trn_done | input | 1 | Transfer complete strobe |
| ev_setup_done | input | 1 | SETUP transaction complete strobe |
| bus_idle | input | 1 | Sampled bus line state is idle |
| suspended | output | 1 | Block is in the suspend state |
| irq_level | output | 2 | Interrupt request level, zero when no request is pending |

## Verification
Software can clear a flag on the same edge at which a hardware strobe, or the idle timer, sets it. The bench provokes this on purpose with a directed clear write that coincides with a CRC strobe. Random writes to the clear alias also land on edges where event strobes fire. Each result is judged against a bench model in which the set from hardware overrides the clear. The suspend and resume paths are checked in the same way while flag writes are in flight.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int FLAG_W   = 8;
    localparam int TRN_W    = 2;
    localparam int LVL_W    = 2;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 8;

    // flag bit positions, software-visible
    localparam int FB_SOF     = 7;
    localparam int FB_SUSPEND = 6;
    localparam int FB_RESUME  = 5;
    localparam int FB_RESET   = 4;
    localparam int FB_CRC     = 3;
    localparam int FB_UNF     = 2;
    localparam int FB_OVF     = 1;
    localparam int FB_STALL   = 0;

    localparam int TB_TRN     = 1;
    localparam int TB_SETUP   = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_FLAG_SET = 3'd0,
        A_FLAG_CLR = 3'd1,
        A_TRN_EN   = 3'd2,
        A_LEVEL    = 3'd3,
        A_TRN_FLAG = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [TRN_W-1:0] trn_en;
        logic [LVL_W-1:0] level;
    } ctl_regs_s;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int IDLE_CYCLES = 48000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    output logic suspend_evt,
    output logic resume_evt,
    output logic suspended
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(IDLE_CYCLES);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             susp;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        suspend_evt = bus_idle && (tmr_q.cnt == LIMIT_M1);
        resume_evt  = tmr_q.susp && !bus_idle;
        if (!bus_idle) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt != LIMIT) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
        if (suspend_evt) begin
            tmr_d.susp = 1'b1;
        end else if (!bus_idle) begin
            tmr_d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign suspended = tmr_q.susp;

    AST_SUSP_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_evt |=> suspended); // R7
    AST_SUSP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_evt |=> !suspend_evt); // R6
    AST_RESUME_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        resume_evt |=> !suspended); // R7
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] flags
);
    logic [W-1:0] flags_d, flags_q;
    logic [W-1:0] set_m, clr_m;

    always_comb begin
        set_m   = set_we ? wdata : '0;
        clr_m   = clr_we ? wdata : '0;
        // hardware set is applied last so it overrides a software clear
        flags_d = ((flags_q | set_m) & ~clr_m) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R5
    AST_W1S_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((flags & $past(wdata)) == $past(wdata))); // R2
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((flags & $past(wdata & ~hw_set)) == '0)); // R3
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
    import usb_irq_pkg::*;
#(
    parameter int IDLE_CYCLES = 48000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ev_sof,
    input  logic              ev_bus_reset,
    input  logic              ev_crc_err,
    input  logic              ev_underflow,
    input  logic              ev_overflow,
    input  logic              ev_stall,
    input  logic              ev_trn_done,
    input  logic              ev_setup_done,
    input  logic              bus_idle,
    output logic              suspended,
    output logic [LVL_W-1:0]  irq_level
);
    logic              suspend_evt, resume_evt;
    logic [FLAG_W-1:0] flag_hw, flags;
    logic [TRN_W-1:0]  trn_hw, trn_flags;
    logic              we_set, we_clr, we_en, we_lvl, we_trn;
    ctl_regs_s         ctl_d, ctl_q;
    logic              pending;

    usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_idle    (bus_idle),
        .suspend_evt (suspend_evt),
        .resume_evt  (resume_evt),
        .suspended   (suspended)
    );

    always_comb begin
        we_set = reg_wr_en && (reg_addr == A_FLAG_SET);
        we_clr = reg_wr_en && (reg_addr == A_FLAG_CLR);
        we_en  = reg_wr_en && (reg_addr == A_TRN_EN);
        we_lvl = reg_wr_en && (reg_addr == A_LEVEL);
        we_trn = reg_wr_en && (reg_addr == A_TRN_FLAG);

        flag_hw              = '0;
        flag_hw[FB_SOF]      = ev_sof;
        flag_hw[FB_SUSPEND]  = suspend_evt;
        flag_hw[FB_RESUME]   = resume_evt;
        flag_hw[FB_RESET]    = ev_bus_reset;
        flag_hw[FB_CRC]      = ev_crc_err;
        flag_hw[FB_UNF]      = ev_underflow;
        flag_hw[FB_OVF]      = ev_overflow;
        flag_hw[FB_STALL]    = ev_stall;

        trn_hw               = '0;
        trn_hw[TB_TRN]       = ev_trn_done;
        trn_hw[TB_SETUP]     = ev_setup_done;
    end

    usb_flag_bank #(.W(FLAG_W)) u_evt_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (we_set),
        .clr_we (we_clr),
        .wdata  (reg_wdata[FLAG_W-1:0]),
        .hw_set (flag_hw),
        .flags  (flags)
    );

    usb_flag_bank #(.W(TRN_W)) u_trn_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (1'b0),
        .clr_we (we_trn),
        .wdata  (reg_wdata[TRN_W-1:0]),
        .hw_set (trn_hw),
        .flags  (trn_flags)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (we_en)  ctl_d.trn_en = reg_wdata[TRN_W-1:0];
        if (we_lvl) ctl_d.level  = reg_wdata[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_FLAG_SET, A_FLAG_CLR: reg_rdata[FLAG_W-1:0] = flags;
            A_TRN_EN:               reg_rdata[TRN_W-1:0]  = ctl_q.trn_en;
            A_LEVEL:                reg_rdata[LVL_W-1:0]  = ctl_q.level;
            A_TRN_FLAG:             reg_rdata[TRN_W-1:0]  = trn_flags;
            default:                reg_rdata             = '0;
        endcase
    end

    always_comb begin
        pending   = (|flags) || (|(trn_flags & ctl_q.trn_en));
        irq_level = pending ? ctl_q.level : '0;
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_TRN_EN) |-> (reg_rdata[DATA_W-1:TRN_W] == '0)); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags == '0) && ((trn_flags & ctl_q.trn_en) == '0)) |-> (irq_level == '0)); // R10
    AST_ALIAS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_FLAG_CLR) |-> (reg_rdata[FLAG_W-1:0] == flags)); // R4
endmodule

// File: tb/sim_usb_irq_flags.sv
module sim_usb_irq_flags;
    localparam int CLK_PERIOD = 10;
    localparam int LIM        = 20;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_wr_en;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [7:0] ev;   // {sof,busrst,crc,unf,ovf,stall,trn,setup}
    logic       bus_idle;
    logic       suspended;
    logic [1:0] irq_level;

    int n_chk  = 0;
    int n_fail = 0;

    // bench model state
    logic [7:0] m_flags;
    logic [1:0] m_trn, m_en, m_lvl;
    logic       m_susp;
    int         m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_irq_flags #(.IDLE_CYCLES(LIM)) u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_sof(ev[7]), .ev_bus_reset(ev[6]), .ev_crc_err(ev[5]),
        .ev_underflow(ev[4]), .ev_overflow(ev[3]), .ev_stall(ev[2]),
        .ev_trn_done(ev[1]), .ev_setup_done(ev[0]),
        .bus_idle(bus_idle), .suspended(suspended), .irq_level(irq_level)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] m_read(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return m_flags;
            3'd2:       return {6'b0, m_en};
            3'd3:       return {6'b0, m_lvl};
            3'd4:       return {6'b0, m_trn};
            default:    return 8'h00;
        endcase
    endfunction

    function automatic logic [1:0] m_irq();
        if (m_flags != 0 || (m_trn & m_en) != 0) return m_lvl;
        return 2'b00;
    endfunction

    // one clock with the current inputs; model follows the requirements
    task automatic tick();
        logic       sp, rs;
        logic [7:0] hw, setm, clrm;
        sp   = bus_idle && (m_cnt == LIM - 1);                 // R6
        rs   = m_susp && !bus_idle;                            // R7
        hw   = {ev[7], sp, rs, ev[6], ev[5], ev[4], ev[3], ev[2]};
        setm = (reg_wr_en && reg_addr == 3'd0) ? reg_wdata : 8'h00;
        clrm = (reg_wr_en && reg_addr == 3'd1) ? reg_wdata : 8'h00;
        @(posedge clk);
        #1;
        m_flags = ((m_flags | setm) & ~clrm) | hw;             // R5 hw wins
        m_trn   = (m_trn & ~((reg_wr_en && reg_addr == 3'd4) ? reg_wdata[1:0] : 2'b00)) | ev[1:0];
        if (reg_wr_en && reg_addr == 3'd2) m_en  = reg_wdata[1:0];
        if (reg_wr_en && reg_addr == 3'd3) m_lvl = reg_wdata[1:0];
        if (sp) m_susp = 1'b1; else if (!bus_idle) m_susp = 1'b0;
        if (!bus_idle) m_cnt = 0; else if (m_cnt != LIM) m_cnt = m_cnt + 1;
        chk("R10 irq_level", {6'b0, irq_level}, {6'b0, m_irq()});
        chk("R7 suspended", {7'b0, suspended}, {7'b0, m_susp});
        chk("R4 rdata", reg_rdata, m_read(reg_addr));
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                       input logic [7:0] e, input logic idle);
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd; ev = e; bus_idle = idle;
        tick();
    endtask

    task automatic rd(input logic [2:0] a);
        reg_wr_en = 1'b0; ev = 8'h00; reg_addr = a;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; reg_wr_en = 0; reg_addr = 0; reg_wdata = 0; ev = 0; bus_idle = 0;
        m_flags = 0; m_trn = 0; m_en = 0; m_lvl = 0; m_susp = 0; m_cnt = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd0); chk("R1 flags", reg_rdata, 8'h00);
        rd(3'd2); chk("R1 enable", reg_rdata, 8'h00);
        rd(3'd3); chk("R1 level", reg_rdata, 8'h00);
        chk("R1 irq", {6'b0, irq_level}, 8'h00);
        chk("R1 suspended", {7'b0, suspended}, 8'h00);

        // R2 set alias, zero bits keep
        cyc(1, 3'd0, 8'hA5, 8'h00, 0);
        rd(3'd0); chk("R2 set", reg_rdata, 8'hA5);
        rd(3'd1); chk("R4 alias", reg_rdata, 8'hA5);
        cyc(1, 3'd0, 8'h00, 8'h00, 0);
        rd(3'd0); chk("R2 zero write", reg_rdata, 8'hA5);
        // R3 clear alias
        cyc(1, 3'd1, 8'h81, 8'h00, 0);
        rd(3'd1); chk("R3 clear", reg_rdata, 8'h24);
        cyc(1, 3'd1, 8'h00, 8'h00, 0);
        rd(3'd0); chk("R3 zero write", reg_rdata, 8'h24);
        // R5 collision: clear bits 3,2 while CRC strobe (bit 3) fires
        cyc(1, 3'd1, 8'h0C, 8'h20, 0);
        rd(3'd0); chk("R5 hw wins", reg_rdata, 8'h28);
        // R8 reserved enable bits
        cyc(1, 3'd2, 8'hFF, 8'h00, 0);
        rd(3'd2); chk("R8 enable rsvd", reg_rdata, 8'h03);
        // R10 level zero keeps quiet
        chk("R10 level zero", {6'b0, irq_level}, 8'h00);
        cyc(1, 3'd3, 8'hFE, 8'h00, 0);
        rd(3'd3); chk("R10 level rsvd", reg_rdata, 8'h02);
        chk("R10 irq level", {6'b0, irq_level}, 8'h02);
        cyc(1, 3'd1, 8'hFF, 8'h00, 0);
        chk("R10 cleared quiet", {6'b0, irq_level}, 8'h00);
        // R9 transaction flags
        cyc(0, 3'd4, 8'h00, 8'h02, 0);
        rd(3'd4); chk("R9 trn set", reg_rdata, 8'h02);
        chk("R10 trn enabled irq", {6'b0, irq_level}, 8'h02);
        cyc(1, 3'd4, 8'hFD, 8'h00, 0);
        rd(3'd4); chk("R9 zero keeps", reg_rdata, 8'h02);
        cyc(1, 3'd4, 8'h02, 8'h00, 0);
        rd(3'd4); chk("R9 trn clear", reg_rdata, 8'h00);
        // R6 idle restart: LIM-1 idle, one busy, then LIM idle
        for (int i = 0; i < LIM - 1; i++) cyc(0, 3'd0, 8'h00, 8'h00, 1);
        rd(3'd0); chk("R6 not yet", reg_rdata, 8'h00);
        cyc(0, 3'd0, 8'h00, 8'h00, 0);
        rd(3'd0); chk("R7 no resume unsuspended", reg_rdata, 8'h00);
        for (int i = 0; i < LIM - 1; i++) cyc(0, 3'd0, 8'h00, 8'h00, 1);
        rd(3'd0); chk("R6 restarted", reg_rdata, 8'h00);
        cyc(0, 3'd0, 8'h00, 8'h00, 1);
        rd(3'd0); chk("R6 suspend flag", reg_rdata, 8'h40);
        chk("R7 suspended set", {7'b0, suspended}, 8'h01);
        cyc(1, 3'd1, 8'h40, 8'h00, 1);
        for (int i = 0; i < 5; i++) cyc(0, 3'd0, 8'h00, 8'h00, 1);
        rd(3'd0); chk("R6 once per stretch", reg_rdata, 8'h00);
        cyc(0, 3'd0, 8'h00, 8'h00, 0);
        rd(3'd0); chk("R7 resume flag", reg_rdata, 8'h20);
        chk("R7 left suspend", {7'b0, suspended}, 8'h00);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] e;
            for (int b = 0; b < 8; b++) e[b] = ($urandom % 16) == 0;
            cyc(($urandom % 4) == 0, 3'($urandom % 6), 8'($urandom),
                e, ($urandom % 48) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule